// File: doc/BRIEF.md
# Clipped Delta Encoder with Sparse Index List

This block sits in front of a matrix-vector engine that runs in a reduced-precision mode. For every input element it takes the current value minus the value seen at the same position in the previous vector. A difference whose magnitude is too small to matter becomes zero. Each remaining difference is scaled down and narrowed to a signed 8-bit value. The survivors leave through a write port, and their positions are kept in a short list. When the vector ends, a sequencer walks that list in the order it was filled and emits (index, delta) pairs. The downstream engine therefore fetches weight columns only for those indices and never for a zero delta.

Elements come in as a stream. A last-element marker closes each vector. Software programs the clipping shift `w`. The block does nothing unless the approximate mode input is high. The list holds 64 entries. Survivors beyond that are dropped and a flag records the loss.

Top module: `delta_sparse_gen`

## Requirements
- R1: When `approx_en` is low, `in_ready` is low, no element is accepted, nothing is written and the stored previous values stay unchanged.
- R2: The delta for element `k` of a vector equals the accepted value minus the value last accepted at position `k`. Every stored previous value is zero after reset. Each accepted element replaces the stored value at its position, whether it survives or not.
- R3: A delta whose magnitude is below 2^w (w = `clip_shift`) is not a survivor. A delta with magnitude of 2^w or more is a survivor.
- R4: A survivor's 8-bit value is the delta arithmetically shifted right by w, saturated to the range -128..127. This value is never zero.
- R5: The survivor is presented on `wr_en`/`wr_slot`/`wr_idx`/`wr_val` in the same cycle its element is offered and accepted. `wr_slot` counts 0, 1, 2, ... in production order, and `wr_idx` is the element's position in the vector (the first element is 0).
- R6: The list is cleared at the start of every vector. The first survivor of a new vector uses slot 0, and `ovf_flag` returns to 0 once the first element of the new vector is accepted.
- R7: A survivor that arrives after 64 have been stored is dropped: `wr_en` stays low for it. `ovf_flag` goes high after that element's clock edge and stays high through read-out.
- R8: Take the clock edge that accepts the last element. During the N cycles after it, `out_valid` is high and `out_idx`/`out_delta` give the stored pairs in slot order, one per cycle. The next cycle has `done` high for exactly one cycle with `out_valid` low.
- R9: A vector with no survivors gives `done` in the first cycle after its last element is accepted, and `out_valid` never goes high for it.
- R10: From the edge that accepts a last element until `done` has been shown, `in_ready` is low, and elements offered in that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| approx_en | input | 1 | Approximate mode selected; the path is idle otherwise |
| clip_shift | input | 4 | Clipping shift w |
| in_valid | input | 1 | Input element offered |
| in_data | input | 16 | Signed input element |
| in_last | input | 1 | Marks the last element of a vector |
| in_ready | output | 1 | Element accepted when high together with in_valid |
| wr_en | output | 1 | Survivor write strobe |
| wr_slot | output | 6 | List slot being written |
| wr_idx | output | 8 | Element index of the survivor |
| wr_val | output | 8 | Signed 8-bit survivor value |
| out_valid | output | 1 | Read-out pair valid |
| out_idx | output | 8 | Index to fetch a weight column for |
| out_delta | output | 8 | Signed 8-bit delta for that index |
| done | output | 1 | One-cycle end of read-out |
| ovf_flag | output | 1 | Survivors were dropped in the current vector |

## Verification
The bench puts deltas exactly at ±2^w and one below it. A compare that is off by one, or a threshold taken on the signed value instead of the magnitude, would keep or drop the wrong elements and shift the slot numbering. It drives deltas large enough to saturate in both directions, where a design that truncates instead would wrap to small values of the wrong sign. It sends an all-unchanged vector, a vector offered with the mode off, and a vector of 80 survivors followed by a short vector. A design that skips the zero-survivor `done`, updates history while idle, or fails to restart the slot count and overflow flag would emit wrong pairs or hang.

// File: rtl/dsg_pkg.sv
`timescale 1ns/1ps
package dsg_pkg;
  typedef enum logic [0:0] {
    ST_GATHER = 1'b0,
    ST_EMIT   = 1'b1
  } dsg_state_e;
endpackage

// File: rtl/dsg_delta_clip.sv
`timescale 1ns/1ps
// Difference, magnitude clip and narrowing of one element.
module dsg_delta_clip #(
  parameter int DW = 16,
  parameter int QW = 8,
  parameter int SW = 4
) (
  input  logic [DW-1:0] cur,
  input  logic [DW-1:0] prev,
  input  logic [SW-1:0] shift,
  output logic          keep,
  output logic [QW-1:0] q
);
  localparam logic signed [DW:0] QMAX = (DW+1)'((1 << (QW-1)) - 1);
  localparam logic signed [DW:0] QMIN = ~QMAX;

  logic signed [DW:0] diff;
  logic signed [DW:0] scaled;
  logic        [DW:0] mag;
  logic        [DW:0] limit;

  always_comb begin
    diff   = $signed({cur[DW-1], cur}) - $signed({prev[DW-1], prev});
    mag    = diff[DW] ? -diff : diff;
    limit  = (DW+1)'(1) << shift;
    keep   = (mag >= limit);
    scaled = diff >>> shift;
    if (scaled > QMAX)      q = QMAX[QW-1:0];
    else if (scaled < QMIN) q = QMIN[QW-1:0];
    else                    q = scaled[QW-1:0];
  end
endmodule

// File: rtl/dsg_prev_store.sv
`timescale 1ns/1ps
// History of the previous vector, one word per element position.
module dsg_prev_store #(
  parameter int DW    = 16,
  parameter int NELEM = 256,
  localparam int IW   = $clog2(NELEM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [NELEM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NELEM; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[addr] <= wdata;
    end
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/dsg_slot_store.sv
`timescale 1ns/1ps
// Survivor list: element index and narrowed delta per slot.
module dsg_slot_store #(
  parameter int DEPTH = 64,
  parameter int IW    = 8,
  parameter int QW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] widx,
  input  logic [QW-1:0] wval,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] ridx,
  output logic [QW-1:0] rval
);
  logic [IW-1:0] idx_mem [DEPTH];
  logic [QW-1:0] val_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      idx_mem[waddr] <= widx;
      val_mem[waddr] <= wval;
    end
  end

  assign ridx = idx_mem[raddr];
  assign rval = val_mem[raddr];
endmodule

// File: rtl/delta_sparse_gen.sv
`timescale 1ns/1ps
module delta_sparse_gen #(
  parameter int DW    = 16,
  parameter int QW    = 8,
  parameter int SW    = 4,
  parameter int NELEM = 256,
  parameter int DEPTH = 64,
  localparam int IW   = $clog2(NELEM),
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          approx_en,
  input  logic [SW-1:0] clip_shift,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          in_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_slot,
  output logic [IW-1:0] wr_idx,
  output logic [QW-1:0] wr_val,
  output logic          out_valid,
  output logic [IW-1:0] out_idx,
  output logic [QW-1:0] out_delta,
  output logic          done,
  output logic          ovf_flag
);
  import dsg_pkg::*;

  dsg_state_e    st_q, st_d;
  logic [IW-1:0] elem_q, elem_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] ptr_q, ptr_d;
  logic          ovf_q, ovf_d;
  logic          fresh_q, fresh_d;

  logic          accept, keep, room, more, upd_en, base_ovf;
  logic [CW-1:0] base_cnt;
  logic [DW-1:0] prev_val;
  logic [QW-1:0] q_val;

  assign in_ready = approx_en && (st_q == ST_GATHER);
  assign accept   = in_valid && in_ready;

  dsg_prev_store #(.DW(DW), .NELEM(NELEM)) u_prev (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (accept),
    .addr  (elem_q),
    .wdata (in_data),
    .rdata (prev_val)
  );

  dsg_delta_clip #(.DW(DW), .QW(QW), .SW(SW)) u_clip (
    .cur   (in_data),
    .prev  (prev_val),
    .shift (clip_shift),
    .keep  (keep),
    .q     (q_val)
  );

  // A new vector starts from an empty list.
  assign base_cnt = fresh_q ? '0 : cnt_q;
  assign base_ovf = fresh_q ? 1'b0 : ovf_q;
  assign room     = (base_cnt < CW'(DEPTH));

  assign wr_en   = accept && keep && room;
  assign wr_slot = base_cnt[AW-1:0];
  assign wr_idx  = elem_q;
  assign wr_val  = q_val;

  dsg_slot_store #(.DEPTH(DEPTH), .IW(IW), .QW(QW)) u_slots (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_slot),
    .widx  (wr_idx),
    .wval  (wr_val),
    .raddr (ptr_q[AW-1:0]),
    .ridx  (out_idx),
    .rval  (out_delta)
  );

  assign more      = (ptr_q < cnt_q);
  assign out_valid = (st_q == ST_EMIT) && more;
  assign done      = (st_q == ST_EMIT) && !more;
  assign ovf_flag  = ovf_q;
  assign upd_en    = accept || (st_q == ST_EMIT);

  always_comb begin
    st_d    = st_q;
    elem_d  = elem_q;
    cnt_d   = cnt_q;
    ptr_d   = ptr_q;
    ovf_d   = ovf_q;
    fresh_d = fresh_q;
    if (accept) begin
      cnt_d   = base_cnt + CW'(wr_en);
      ovf_d   = base_ovf | (keep & ~room);
      fresh_d = in_last;
      elem_d  = in_last ? '0 : elem_q + IW'(1);
      if (in_last) begin
        st_d  = ST_EMIT;
        ptr_d = '0;
      end
    end
    if (st_q == ST_EMIT) begin
      if (more) ptr_d = ptr_q + CW'(1);
      else      st_d  = ST_GATHER;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_GATHER;
      elem_q  <= '0;
      cnt_q   <= '0;
      ptr_q   <= '0;
      ovf_q   <= 1'b0;
      fresh_q <= 1'b1;
    end else if (upd_en) begin
      st_q    <= st_d;
      elem_q  <= elem_d;
      cnt_q   <= cnt_d;
      ptr_q   <= ptr_d;
      ovf_q   <= ovf_d;
      fresh_q <= fresh_d;
    end
  end
endmodule

// File: rtl/dsg_checker.sv
`timescale 1ns/1ps
module dsg_checker #(
  parameter int IW = 8,
  parameter int QW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          approx_en,
  input logic          in_valid,
  input logic          in_ready,
  input logic          wr_en,
  input logic [QW-1:0] wr_val,
  input logic          out_valid,
  input logic [IW-1:0] out_idx,
  input logic          done,
  input logic          ovf_flag
);
  assert_mode_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (approx_en && in_valid && in_ready));

  assert_nonzero_survivor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_val != '0));

  assert_ovf_on_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(in_valid && in_ready));

  assert_ascending_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> (out_idx > $past(out_idx)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && out_valid));

  assert_input_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || done) |-> !in_ready);
endmodule

bind delta_sparse_gen dsg_checker #(.IW(IW), .QW(QW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .approx_en (approx_en),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .wr_en     (wr_en),
  .wr_val    (wr_val),
  .out_valid (out_valid),
  .out_idx   (out_idx),
  .done      (done),
  .ovf_flag  (ovf_flag)
);

// File: tb/tb_delta_sparse_gen.sv
`timescale 1ns/1ps
module tb_delta_sparse_gen;
  localparam int DW = 16, QW = 8, SW = 4, NELEM = 256, DEPTH = 64;
  localparam int IW = $clog2(NELEM), AW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          approx_en;
  logic [SW-1:0] clip_shift;
  logic          in_valid;
  logic [DW-1:0] in_data;
  logic          in_last;
  logic          in_ready, wr_en, out_valid, done, ovf_flag;
  logic [AW-1:0] wr_slot;
  logic [IW-1:0] wr_idx, out_idx;
  logic [QW-1:0] wr_val, out_delta;

  delta_sparse_gen dut (
    .clk(clk), .rst_n(rst_n), .approx_en(approx_en), .clip_shift(clip_shift),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_idx(wr_idx), .wr_val(wr_val),
    .out_valid(out_valid), .out_idx(out_idx), .out_delta(out_delta),
    .done(done), .ovf_flag(ovf_flag)
  );

  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int prev_m [NELEM];
  int exp_idx [$];
  int exp_val [$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model(input int idx, input int val, input int w,
                                output bit keep, output int q);
    int d, mag, s;
    d    = val - prev_m[idx];
    mag  = (d < 0) ? -d : d;
    keep = (mag >= (1 << w));
    s    = d >>> w;
    q    = (s > 127) ? 127 : ((s < -128) ? -128 : s);
  endfunction

  // Sends one vector, checks the write port per element and the read-out.
  task automatic run_vector(input int vals[], input int w, input string tag);
    int  slot = 0;
    bit  ovf_exp = 0;
    bit  keep;
    int  q;
    exp_idx.delete();
    exp_val.delete();
    clip_shift = SW'(w);
    for (int i = 0; i < vals.size(); i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = DW'(vals[i]);
      in_last  = (i == vals.size() - 1);
      #1;
      model(i, vals[i], w, keep, q);
      chk("R1", {tag, " in_ready"}, int'(in_ready), 1);
      chk("R3/R5/R7", {tag, " wr_en"}, int'(wr_en), int'(keep && slot < DEPTH));
      if (keep && slot < DEPTH) begin
        chk("R5/R6", {tag, " wr_slot"}, int'(wr_slot), slot);
        chk("R5", {tag, " wr_idx"}, int'(wr_idx), i);
        chk("R2/R4", {tag, " wr_val"}, int'($signed(wr_val)), q);
      end
      prev_m[i] = vals[i];
      if (keep) begin
        if (slot < DEPTH) begin
          exp_idx.push_back(i);
          exp_val.push_back(q);
          slot++;
        end else ovf_exp = 1;
      end
    end
    // Keep offering junk during read-out: it must be ignored.
    @(negedge clk);
    in_last = 1'b0;
    in_data = 16'h7abc;
    for (int k = 0; k < exp_idx.size(); k++) begin
      #1;
      chk("R8", {tag, " out_valid"}, int'(out_valid), 1);
      chk("R8", {tag, " out_idx"}, int'(out_idx), exp_idx[k]);
      chk("R8", {tag, " out_delta"}, int'($signed(out_delta)), exp_val[k]);
      chk("R10", {tag, " in_ready"}, int'(in_ready), 0);
      @(negedge clk);
    end
    #1;
    chk("R8/R9", {tag, " done"}, int'(done), 1);
    chk("R9", {tag, " out_valid at done"}, int'(out_valid), 0);
    chk("R10", {tag, " in_ready at done"}, int'(in_ready), 0);
    chk("R7", {tag, " ovf_flag"}, int'(ovf_flag), int'(ovf_exp));
    in_valid = 1'b0;
    @(negedge clk);
    #1;
    chk("R8", {tag, " done one cycle"}, int'(done), 0);
  endtask

  task automatic t_reset();
    #1;
    chk("R8", "reset out_valid", int'(out_valid), 0);
    chk("R8", "reset done", int'(done), 0);
    chk("R7", "reset ovf_flag", int'(ovf_flag), 0);
    chk("R1", "reset in_ready", int'(in_ready), 1);
  endtask

  task automatic t_first_vector();
    int v[] = new[8];
    // From zero history: small, large, saturating both ways, boundary 16.
    v = '{3, 100, -100, 5000, -5000, 16, -16, 15};
    run_vector(v, 4, "first");
  endtask

  task automatic t_unchanged();
    int v[] = new[8];
    for (int i = 0; i < 8; i++) v[i] = prev_m[i];
    run_vector(v, 4, "unchanged");
  endtask

  task automatic t_mode_off();
    approx_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = DW'(9000 + i);
      in_last  = (i == 3);
      #1;
      chk("R1", "mode off in_ready", int'(in_ready), 0);
      chk("R1", "mode off wr_en", int'(wr_en), 0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    #1;
    chk("R1", "mode off done", int'(done), 0);
    chk("R1", "mode off out_valid", int'(out_valid), 0);
    approx_en = 1'b1;
  endtask

  task automatic t_boundaries();
    int v[] = new[8];
    int d[8] = '{3, 4, -4, -3, -5, 0, 7, 8};
    for (int i = 0; i < 8; i++) v[i] = prev_m[i] + d[i];
    run_vector(v, 2, "bound w2");
    for (int i = 0; i < 8; i++) v[i] = prev_m[i] + ((i % 2 == 0) ? 1 : 0);
    run_vector(v, 0, "bound w0");
  endtask

  task automatic t_overflow();
    int v[] = new[80];
    int s[] = new[6];
    for (int i = 0; i < 80; i++) v[i] = prev_m[i] + 200 + i;
    run_vector(v, 3, "overflow");
    for (int i = 0; i < 6; i++) s[i] = prev_m[i] + ((i == 2 || i == 5) ? -300 : 0);
    run_vector(s, 3, "after ovf");
  endtask

  initial begin
    for (int i = 0; i < NELEM; i++) prev_m[i] = 0;
    rst_n      = 1'b0;
    approx_en  = 1'b1;
    clip_shift = '0;
    in_valid   = 1'b0;
    in_data    = '0;
    in_last    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_vector();
    t_unchanged();
    t_mode_off();
    t_boundaries();
    t_overflow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule